// File: doc/BRIEF.md
# Memory Protection Checker with Modified-Privilege Data Accesses

This block decides, for every fetch, load or store the core presents, whether the access is permitted by a small set of naturally aligned power-of-two protection regions. It also holds the current privilege level and the two status fields that let machine-mode software perform loads and stores at the privilege level saved by the last trap, while its own instruction fetches keep running at machine privilege.

Each request is judged in the same cycle it is presented. The block picks an effective privilege: fetches always use the real privilege. Data accesses use the saved privilege when the core is in machine mode with the modify-privilege flag set. It then checks every byte of the access against the regions, lowest-numbered region first. A denied access raises a fault with the matching exception cause. Trap entry and trap return update the saved privilege, the current privilege and the modify-privilege flag.

Software writes the region settings and the status word through simple write ports. The status word reads back with only its two live fields.

Top module: `pmp_mprv_unit`

## Requirements
- R1: After reset the privilege is machine (3), the status word reads 0, every region is off and no access faults.
- R2: In the status word, bit 17 is the modify-privilege flag and bits 12:11 are the saved privilege (3 machine, 0 user). All other bits read 0. A saved-privilege write of 1 or 2 is stored as 0.
- R3: A load or store made in machine mode with the modify-privilege flag set is judged at the saved privilege. Otherwise it is judged at the current privilege. The judging privilege is visible on `eff_priv_o`.
- R4: Fetches are always judged at the current privilege, whatever the two status fields hold.
- R5: A denied fetch gives cause 1, a denied load gives cause 5 and a denied store gives cause 7. When nothing is denied the cause output is 0.
- R6: Region settings byte layout: bit 0 read, bit 1 write, bit 2 execute, bits 4:3 mode, bit 7 lock. Mode 3 selects a power-of-two region and any other mode turns the region off. A region whose address word has k trailing ones covers 2^(k+3) bytes aligned to that size. An address word of all ones covers the whole space. Writes to either register of a locked region are ignored.
- R7: A user-level access that hits no region is denied. A machine-level access that hits no region is allowed. A machine-level access that hits an unlocked region is allowed.
- R8: Among the regions touched by any byte of the access, the lowest-numbered one decides. If that region does not hold every byte, the access is denied. Otherwise the decision follows its read, write or execute bit, except for the machine-level access to an unlocked region covered by R7.
- R9: Trap entry copies the current privilege into the saved privilege, sets machine privilege and leaves the modify-privilege flag alone.
- R10: Trap return sets the privilege from the saved privilege and sets the saved privilege to user. It clears the modify-privilege flag when the new privilege is not machine.
- R11: The fault and cause outputs depend combinationally on the request inputs and change with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| entry_sel_i | input | 2 | Region index for configuration writes |
| cfg_we_i | input | 1 | Write the settings byte of the selected region |
| cfg_wdata_i | input | 8 | Settings byte |
| addr_we_i | input | 1 | Write the address word of the selected region |
| addr_wdata_i | input | 32 | Address word (byte address shifted right by 2, trailing ones encode size) |
| ms_we_i | input | 1 | Write the status word |
| ms_wdata_i | input | 32 | Status word write data |
| trap_i | input | 1 | Trap entry this cycle (wins over trap return) |
| mret_i | input | 1 | Trap return this cycle |
| req_addr_i | input | 32 | Byte address of the access |
| req_size_i | input | 2 | Access size as log2 of the byte count |
| req_kind_i | input | 2 | 0 fetch, 1 load, 2 store |
| priv_o | output | 2 | Current privilege |
| ms_rdata_o | output | 32 | Status word read data |
| eff_priv_o | output | 2 | Privilege used to judge the present request |
| fault_o | output | 1 | Access denied |
| fault_cause_o | output | 5 | Exception cause of a denied access, else 0 |

## Verification
The sweep covers four privilege setups: machine with the flag clear, the flag set with saved machine, the flag set with saved user, and real user mode. Each is run against overlapping regions, a locked execute-only region and a large upper region, using access sizes of 1, 2 and 4 bytes. If the design let the flag reach fetches, fetches in the flag-set, saved-user setup would fault. A design that ignored the flag would pass user-denied loads. Accesses that straddle a region edge catch a design that checks only the first byte. A store inside the read-only region nested at index 0 catches a design that gives the wider, higher-numbered region priority. Explicit trap sequences catch a trap that clears the flag or copies the wrong privilege, a return that leaves the flag set, and a lock that still accepts writes.

// File: rtl/pmp_mprv_pkg.sv
package pmp_mprv_pkg;
  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_M = 2'b11;

  localparam logic [1:0] KIND_FETCH = 2'd0;
  localparam logic [1:0] KIND_LOAD  = 2'd1;
  localparam logic [1:0] KIND_STORE = 2'd2;

  localparam logic [1:0] MODE_NAPOT = 2'd3;

  localparam logic [4:0] CAUSE_NONE  = 5'd0;
  localparam logic [4:0] CAUSE_FETCH = 5'd1;
  localparam logic [4:0] CAUSE_LOAD  = 5'd5;
  localparam logic [4:0] CAUSE_STORE = 5'd7;

  localparam int MS_MPRV_BIT = 17;
  localparam int MS_MPP_LSB  = 11;

  typedef struct packed {
    logic lock;
    logic r;
    logic w;
    logic x;
  } perm_t;
endpackage

// File: rtl/pmp_napot_match.sv
module pmp_napot_match #(
  parameter int ADDR_W  = 32,
  localparam int PROBE_W = ADDR_W + 2
) (
  input  logic               en_i,
  input  logic [ADDR_W-1:0]  region_i,
  input  logic [PROBE_W-1:0] probe_i,
  output logic               hit_o
);
  logic [ADDR_W-1:0]  toggled;
  logic [PROBE_W-1:0] ignore_mask;
  logic [PROBE_W-1:0] diff;

  // trailing ones plus the first zero flip on increment: those bits span the region
  assign toggled     = region_i ^ (region_i + ADDR_W'(1));
  assign ignore_mask = {toggled, 2'b11};
  assign diff        = probe_i ^ {region_i, 2'b00};
  assign hit_o       = en_i && ((diff & ~ignore_mask) == '0);
endmodule

// File: rtl/pmp_entry.sv
module pmp_entry
  import pmp_mprv_pkg::*;
#(
  parameter int ADDR_W  = 32,
  localparam int PROBE_W = ADDR_W + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [7:0]         cfg_wdata_i,
  input  logic               addr_we_i,
  input  logic [ADDR_W-1:0]  addr_wdata_i,
  input  logic [PROBE_W-1:0] first_i,
  input  logic [PROBE_W-1:0] last_i,
  output logic               hit_o,
  output logic               full_o,
  output perm_t              perm_o
);
  logic [1:0]        mode_q;
  perm_t             perm_q;
  logic [ADDR_W-1:0] region_q;
  logic              en;
  logic [1:0]        end_hit;
  logic              unused_cfg;

  assign unused_cfg = ^cfg_wdata_i[6:5];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= '0;
      perm_q   <= '0;
      region_q <= '0;
    end else if (!perm_q.lock) begin
      if (cfg_we_i) begin
        mode_q <= cfg_wdata_i[4:3];
        perm_q <= '{lock: cfg_wdata_i[7], r: cfg_wdata_i[0],
                    w: cfg_wdata_i[1], x: cfg_wdata_i[2]};
      end
      if (addr_we_i) region_q <= addr_wdata_i;
    end
  end

  assign en = (mode_q == MODE_NAPOT);

  pmp_napot_match #(.ADDR_W(ADDR_W)) u_lo (
    .en_i(en), .region_i(region_q), .probe_i(first_i), .hit_o(end_hit[0]));
  pmp_napot_match #(.ADDR_W(ADDR_W)) u_hi (
    .en_i(en), .region_i(region_q), .probe_i(last_i), .hit_o(end_hit[1]));

  assign hit_o  = |end_hit;
  assign full_o = &end_hit;
  assign perm_o = perm_q;
endmodule

// File: rtl/pmp_priv_ctrl.sv
module pmp_priv_ctrl
  import pmp_mprv_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ms_we_i,
  input  logic [31:0] ms_wdata_i,
  input  logic        trap_i,
  input  logic        mret_i,
  output logic [1:0]  priv_o,
  output logic        mprv_o,
  output logic [1:0]  mpp_o
);
  logic [1:0] priv_q, mpp_q;
  logic       mprv_q;
  logic       unused_wdata;

  assign unused_wdata = ^{ms_wdata_i[31:18], ms_wdata_i[16:13], ms_wdata_i[10:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      priv_q <= PRIV_M;
      mpp_q  <= PRIV_U;
      mprv_q <= 1'b0;
    end else if (trap_i) begin
      mpp_q  <= priv_q;
      priv_q <= PRIV_M;
    end else if (mret_i) begin
      priv_q <= mpp_q;
      mpp_q  <= PRIV_U;
      if (mpp_q != PRIV_M) mprv_q <= 1'b0;
    end else if (ms_we_i) begin
      mprv_q <= ms_wdata_i[MS_MPRV_BIT];
      mpp_q  <= (ms_wdata_i[MS_MPP_LSB+1:MS_MPP_LSB] == PRIV_M) ? PRIV_M : PRIV_U;
    end
  end

  assign priv_o = priv_q;
  assign mprv_o = mprv_q;
  assign mpp_o  = mpp_q;
endmodule

// File: rtl/pmp_resolve.sv
module pmp_resolve
  import pmp_mprv_pkg::*;
#(
  parameter int N_ENTRIES = 4
) (
  input  logic [N_ENTRIES-1:0] hit_i,
  input  logic [N_ENTRIES-1:0] full_i,
  input  perm_t                perm_i [N_ENTRIES],
  input  logic [1:0]           eff_priv_i,
  input  logic [1:0]           kind_i,
  output logic                 allow_o
);
  logic  found;
  logic  full_sel;
  perm_t perm_sel;
  logic  need;

  always_comb begin
    found    = 1'b0;
    full_sel = 1'b0;
    perm_sel = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (!found && hit_i[i]) begin
        found    = 1'b1;
        full_sel = full_i[i];
        perm_sel = perm_i[i];
      end
    end
  end

  always_comb begin
    unique case (kind_i)
      KIND_FETCH: need = perm_sel.x;
      KIND_LOAD:  need = perm_sel.r;
      default:    need = perm_sel.w;
    endcase
  end

  always_comb begin
    if (!found)                                    allow_o = (eff_priv_i == PRIV_M);
    else if (!full_sel)                            allow_o = 1'b0;
    else if (eff_priv_i == PRIV_M && !perm_sel.lock) allow_o = 1'b1;
    else                                           allow_o = need;
  end
endmodule

// File: rtl/pmp_mprv_unit.sv
module pmp_mprv_unit
  import pmp_mprv_pkg::*;
#(
  parameter int N_ENTRIES = 4,
  parameter int ADDR_W    = 32,
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
  localparam int PROBE_W  = ADDR_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  entry_sel_i,
  input  logic              cfg_we_i,
  input  logic [7:0]        cfg_wdata_i,
  input  logic              addr_we_i,
  input  logic [ADDR_W-1:0] addr_wdata_i,
  input  logic              ms_we_i,
  input  logic [31:0]       ms_wdata_i,
  input  logic              trap_i,
  input  logic              mret_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic [1:0]        req_kind_i,
  output logic [1:0]        priv_o,
  output logic [31:0]       ms_rdata_o,
  output logic [1:0]        eff_priv_o,
  output logic              fault_o,
  output logic [4:0]        fault_cause_o
);
  logic [1:0]           priv, mpp;
  logic                 mprv;
  logic [PROBE_W-1:0]   first, last;
  logic [N_ENTRIES-1:0] hit, full;
  perm_t                perm [N_ENTRIES];
  logic                 allow;

  pmp_priv_ctrl u_priv (
    .clk_i, .rst_ni, .ms_we_i, .ms_wdata_i, .trap_i, .mret_i,
    .priv_o(priv), .mprv_o(mprv), .mpp_o(mpp));

  assign first = {2'b00, req_addr_i};
  assign last  = first + (PROBE_W'(1) << req_size_i) - PROBE_W'(1);

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
    pmp_entry #(.ADDR_W(ADDR_W)) u_entry (
      .clk_i, .rst_ni,
      .cfg_we_i    (cfg_we_i  && entry_sel_i == IDX_W'(g)),
      .cfg_wdata_i,
      .addr_we_i   (addr_we_i && entry_sel_i == IDX_W'(g)),
      .addr_wdata_i,
      .first_i(first), .last_i(last),
      .hit_o(hit[g]), .full_o(full[g]), .perm_o(perm[g]));
  end

  // data accesses borrow the saved privilege; fetches never do
  assign eff_priv_o = (req_kind_i != KIND_FETCH && priv == PRIV_M && mprv) ? mpp : priv;

  pmp_resolve #(.N_ENTRIES(N_ENTRIES)) u_resolve (
    .hit_i(hit), .full_i(full), .perm_i(perm),
    .eff_priv_i(eff_priv_o), .kind_i(req_kind_i), .allow_o(allow));

  assign fault_o = !allow;
  always_comb begin
    if (allow)                          fault_cause_o = CAUSE_NONE;
    else if (req_kind_i == KIND_FETCH)  fault_cause_o = CAUSE_FETCH;
    else if (req_kind_i == KIND_LOAD)   fault_cause_o = CAUSE_LOAD;
    else                                fault_cause_o = CAUSE_STORE;
  end

  assign priv_o = priv;
  always_comb begin
    ms_rdata_o = '0;
    ms_rdata_o[MS_MPRV_BIT] = mprv;
    ms_rdata_o[MS_MPP_LSB+1:MS_MPP_LSB] = mpp;
  end
endmodule

// File: rtl/pmp_mprv_chk.sv
module pmp_mprv_chk
  import pmp_mprv_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic [1:0]  req_kind_i,
  input logic        trap_i,
  input logic        mret_i,
  input logic [1:0]  priv_o,
  input logic [31:0] ms_rdata_o,
  input logic [1:0]  eff_priv_o,
  input logic        fault_o,
  input logic [4:0]  fault_cause_o
);
  p_fetch_priv_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_kind_i == KIND_FETCH |-> eff_priv_o == priv_o);

  p_data_priv_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_kind_i != KIND_FETCH && priv_o == PRIV_M && ms_rdata_o[MS_MPRV_BIT])
      |-> eff_priv_o == ms_rdata_o[MS_MPP_LSB+1:MS_MPP_LSB]);

  p_no_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_o |-> fault_cause_o == CAUSE_NONE);

  p_load_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && req_kind_i == KIND_LOAD) |-> fault_cause_o == CAUSE_LOAD);

  p_trap_entry_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> (priv_o == PRIV_M
                && ms_rdata_o[MS_MPP_LSB+1:MS_MPP_LSB] == $past(priv_o)
                && ms_rdata_o[MS_MPRV_BIT] == $past(ms_rdata_o[MS_MPRV_BIT])));

  p_trap_return_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mret_i && !trap_i) |=> (priv_o == $past(ms_rdata_o[MS_MPP_LSB+1:MS_MPP_LSB])
                             && ms_rdata_o[MS_MPP_LSB+1:MS_MPP_LSB] == PRIV_U
                             && (priv_o == PRIV_M || !ms_rdata_o[MS_MPRV_BIT])));
endmodule

bind pmp_mprv_unit pmp_mprv_chk u_chk (
  .clk_i, .rst_ni, .req_kind_i, .trap_i, .mret_i,
  .priv_o, .ms_rdata_o, .eff_priv_o, .fault_o, .fault_cause_o);

// File: tb/sim_pmp_mprv_unit.sv
module sim_pmp_mprv_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  entry_sel = '0;
  logic        cfg_we = 1'b0, addr_we = 1'b0, ms_we = 1'b0, trap = 1'b0, mret = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [31:0] addr_wdata = '0, ms_wdata = '0, req_addr = '0;
  logic [1:0]  req_size = '0, req_kind = '0;
  logic [1:0]  priv, eff_priv;
  logic [31:0] ms_rdata;
  logic        fault;
  logic [4:0]  cause;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  logic [7:0]  m_cfg  [4];
  logic [31:0] m_addr [4];
  logic [1:0]  m_priv, m_mpp;
  logic        m_mprv;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmp_mprv_unit u0 (
    .clk_i(clk), .rst_ni, .entry_sel_i(entry_sel), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .addr_we_i(addr_we), .addr_wdata_i(addr_wdata), .ms_we_i(ms_we), .ms_wdata_i(ms_wdata),
    .trap_i(trap), .mret_i(mret), .req_addr_i(req_addr), .req_size_i(req_size),
    .req_kind_i(req_kind), .priv_o(priv), .ms_rdata_o(ms_rdata), .eff_priv_o(eff_priv),
    .fault_o(fault), .fault_cause_o(cause));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_entry(input int idx, input logic [7:0] c, input logic [31:0] a);
    entry_sel = 2'(idx);
    addr_wdata = a; addr_we = 1'b1; step(); addr_we = 1'b0;
    cfg_wdata = c;  cfg_we = 1'b1;  step(); cfg_we = 1'b0;
    if (!m_cfg[idx][7]) begin m_cfg[idx] = c; m_addr[idx] = a; end
  endtask

  task automatic wr_ms(input logic [31:0] d);
    ms_wdata = d; ms_we = 1'b1; step(); ms_we = 1'b0;
    m_mprv = d[17];
    m_mpp  = (d[12:11] == 2'b11) ? 2'b11 : 2'b00;
  endtask

  task automatic do_trap();
    trap = 1'b1; step(); trap = 1'b0;
    m_mpp = m_priv; m_priv = 2'b11;
  endtask

  task automatic do_mret();
    mret = 1'b1; step(); mret = 1'b0;
    if (m_mpp != 2'b11) m_mprv = 1'b0;
    m_priv = m_mpp; m_mpp = 2'b00;
  endtask

  function automatic bit in_region(input logic [31:0] a, input longint x);
    int k = 0;
    longint sz, base;
    while (k < 32 && a[k]) k++;
    sz   = longint'(1) << (k + 3);
    base = (longint'(a) << 2) & ~(sz - 1);
    return x >= base && x < base + sz;
  endfunction

  function automatic bit exp_fault(input logic [31:0] ad, input int s, input logic [1:0] kind,
                                   input logic [1:0] ep);
    longint f = longint'(ad);
    longint l = f + (longint'(1) << s) - 1;
    for (int i = 0; i < 4; i++) begin
      if (m_cfg[i][4:3] == 2'd3 && (in_region(m_addr[i], f) || in_region(m_addr[i], l))) begin
        bit perm;
        if (!(in_region(m_addr[i], f) && in_region(m_addr[i], l))) return 1'b1;
        perm = (kind == 0) ? m_cfg[i][2] : (kind == 1) ? m_cfg[i][0] : m_cfg[i][1];
        if (ep == 2'b11 && !m_cfg[i][7]) return 1'b0;
        return !perm;
      end
    end
    return ep != 2'b11;
  endfunction

  task automatic sweep();
    logic [31:0] addrs [12] = '{32'h0, 32'h0FFE, 32'h1000, 32'h1FFC, 32'h3FFE, 32'h4000,
                                32'h8000, 32'h80FE, 32'h7FFFFFFE, 32'h80000000,
                                32'hFFFFFFFC, 32'h12345678};
    for (int ai = 0; ai < 12; ai++) begin
      for (int s = 0; s < 3; s++) begin
        for (int k = 0; k < 3; k++) begin
          logic [1:0] ep;
          bit ef;
          string tag;
          req_addr = addrs[ai]; req_size = 2'(s); req_kind = 2'(k);
          #1;
          ep = (k != 0 && m_priv == 2'b11 && m_mprv) ? m_mpp : m_priv;
          ef = exp_fault(addrs[ai], s, 2'(k), ep);
          tag = (k == 0) ? "R4 R6 R7 R8 R11" : "R3 R6 R7 R8 R11";
          chk(tag, {30'b0, eff_priv}, {30'b0, ep});
          chk(tag, {31'b0, fault}, {31'b0, ef});
          chk("R5", {27'b0, cause}, !ef ? 32'd0 : (k == 0) ? 32'd1 : (k == 1) ? 32'd5 : 32'd7);
        end
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_cfg[i] = '0; m_addr[i] = '0; end
    m_priv = 2'b11; m_mpp = 2'b00; m_mprv = 1'b0;
    req_addr = 32'h1000; req_kind = 2'd1; req_size = 2'd2;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {30'b0, priv}, 32'd3);
    chk("R1", ms_rdata, 32'h0);
    chk("R1", {31'b0, fault}, 32'd0);
    rst_ni = 1'b1;
    step();

    // R2 field positions and legal saved privilege
    wr_ms(32'hFFFF_FFFF);
    chk("R2", ms_rdata, 32'h0002_1800);
    wr_ms(32'h0000_1000);
    chk("R2", ms_rdata, 32'h0);

    // regions: 0 read-only 4KB @0x1000, 1 rw 16KB @0, 2 locked exec 256B @0x8000, 3 rw upper half
    wr_entry(0, 8'h19, 32'h0000_05FF);
    wr_entry(1, 8'h1B, 32'h0000_07FF);
    wr_entry(2, 8'h9C, 32'h0000_201F);
    wr_entry(3, 8'h1B, (32'h8000_0000 | 32'h3FFF_FFFF) >> 2);

    wr_ms(32'h0);        sweep();
    wr_ms(32'h0002_1800); sweep();
    wr_ms(32'h0002_0000); sweep();

    // R10 return to user clears the flag
    do_mret();
    chk("R10", {30'b0, priv}, 32'd0);
    chk("R10", ms_rdata, 32'h0);
    sweep();

    // R9 trap from user
    do_trap();
    chk("R9", {30'b0, priv}, 32'd3);
    chk("R9", ms_rdata, 32'h0);

    // R9 fault under flag with saved user: saved becomes machine, flag kept
    wr_ms(32'h0002_1800);
    wr_ms(32'h0002_0000);
    req_addr = 32'h0000_1000; req_kind = 2'd2; req_size = 2'd2; #1;
    chk("R3 R5", {27'b0, cause}, 32'd7);
    do_trap();
    chk("R9", ms_rdata, 32'h0002_1800);
    chk("R9", {30'b0, priv}, 32'd3);

    // R10 return to machine keeps the flag
    do_mret();
    chk("R10", {30'b0, priv}, 32'd3);
    chk("R10", ms_rdata, 32'h0002_0000);

    // R6 locked region ignores writes
    wr_ms(32'h0);
    wr_entry(2, 8'h1F, 32'h0000_0000);
    req_addr = 32'h0000_8000; req_kind = 2'd1; req_size = 2'd0; #1;
    chk("R6", {27'b0, cause}, 32'd5);
    req_kind = 2'd0; #1;
    chk("R6", {31'b0, fault}, 32'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule